// File: doc/BRIEF.md
# DRAM Bank Timing Tracker

This block holds the per-bank view of a small DRAM controller. Every bank has an open row, or none, and three countdown timers. These timers record how long the bank must wait before it may take a column command, a precharge and an activate. The bank also counts the column accesses and the bytes moved since its row was opened. A scheduler presents one command per cycle: activate, precharge, read or write, with a rank, a bank and a row. The block accepts the command and updates the bank, or it refuses the command and raises a sticky error. Legality flags are published per bank, in global bank order, so that a scheduler can pick only commands that will be accepted. A query port reports row hits and the access counters of any one bank.

Each bank runs a two-state machine:
- `BK_SHUT` is the closed state. The open row then reads as all ones.
- `BK_LIVE` is the row-open state.

The transitions between them are:
- *open*: an activate accepted in `BK_SHUT`.
- *close*: a precharge accepted in `BK_LIVE`.
- *forced close*: a column command in `BK_LIVE` that brings the access count up to the configured cap.

Each rank also has an activate window. It keeps one countdown slot per permitted activate, so no more than `ACT_LIMIT` activates fall inside any `T_WIN`-cycle span.

The worst-case lead a scheduler must plan for before a data beat is T_RP + T_RCD + T_CL. This block supplies the first two of those terms per bank.

Top module: `bank_timing_tracker`

## Requirements
- R1: While reset is held and after it is released, every bank is closed. This means `act_ok` is all ones, `pre_ok` and `col_ok` are zero, `q_open` is 0 and `timing_err` is 0.
- R2: An accepted activate opens the row. The first column command on it is allowed `T_RCD` cycles later and a precharge `T_RAS` cycles later. An activate is accepted only on a closed bank.
- R3: An accepted precharge closes the bank. The next activate to that bank is allowed `T_RP` cycles later.
- R4: After a column command, the next column command to the same bank is allowed `T_CCD` cycles later. After a read, precharge is held off for at least `T_RTP` cycles; after a write, for at least `T_WR` cycles.
- R5: Each accepted column command adds 1 to the bank's access count and `BURST_BYTES` to its byte count. Both counts return to 0 on the bank's next accepted activate.
- R6: The column command that makes the access count equal `MAX_ACC` closes the row by force. The next activate is then allowed `T_RP` cycles after the cycle in which a precharge would have first been allowed.
- R7: Within one rank, an activate is refused while `ACT_LIMIT` activates have been accepted in the last `T_WIN` cycles. An activate stops counting against the limit `T_WIN` cycles after it was accepted. Ranks are counted separately.
- R8: The bank with rank r and bank b sits at bit r*BANKS+b of `act_ok`, `pre_ok` and `col_ok`. With 4 banks per rank, bit 4 is rank 1, bank 0. The command codes on `cmd_op` are 0 activate, 1 precharge, 2 read and 3 write.
- R9: `q_hit` is 1 exactly when the queried bank is open on `q_row`. `q_open`, `q_acc` and `q_bytes` show that bank's state.
- R10: A command whose flag is 0, or a column command whose row differs from the open row, is ignored. It sets `timing_err`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code: 0 activate, 1 precharge, 2 read, 3 write |
| cmd_rank | input | RK_W | Target rank |
| cmd_bank | input | BK_W | Target bank within the rank |
| cmd_row | input | ROW_W | Row to open, or row a column command expects |
| q_rank | input | RK_W | Query rank |
| q_bank | input | BK_W | Query bank |
| q_row | input | ROW_W | Row compared for a hit |
| act_ok | output | NB | Activate legal, per global bank |
| pre_ok | output | NB | Precharge legal, per global bank |
| col_ok | output | NB | Column command legal, per global bank |
| q_open | output | 1 | Queried bank has a row open |
| q_hit | output | 1 | Queried bank is open on q_row |
| q_acc | output | ACC_W | Column accesses since the queried bank's last activate |
| q_bytes | output | BYTE_W | Bytes since the queried bank's last activate |
| timing_err | output | 1 | Sticky: an illegal command was presented |

## Verification
The bench builds the block with its defaults: 2 ranks of 4 banks, an activate cap of 2 per 10-cycle window and a cap of 4 column accesses per row. With those values a third activate in a rank is blocked after a handful of commands, and a fourth read forces a row closed. Rank 1 shares the index space with rank 0, so the global bank mapping and the separate per-rank windows are exercised. Each scripted command waits for its legality flag, and the number of waiting cycles is compared with the timer that the requirements predict.

// File: rtl/bktrk_pkg.sv
package bktrk_pkg;

    typedef enum logic [1:0] {
        OP_ACT = 2'd0,
        OP_PRE = 2'd1,
        OP_RD  = 2'd2,
        OP_WR  = 2'd3
    } bk_op_e;

    typedef enum logic {
        BK_SHUT = 1'b0,
        BK_LIVE = 1'b1
    } bk_state_e;

endpackage

// File: rtl/bktrk_bank_slot.sv
module bktrk_bank_slot
    import bktrk_pkg::*;
#(
    parameter int ROW_W       = 8,
    parameter int TIMER_W     = 5,
    parameter int ACC_W       = 3,
    parameter int BYTE_W      = 8,
    parameter int T_RCD       = 3,
    parameter int T_RAS       = 6,
    parameter int T_RP        = 3,
    parameter int T_CCD       = 2,
    parameter int T_RTP       = 2,
    parameter int T_WR        = 4,
    parameter int MAX_ACC     = 4,
    parameter int BURST_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_act,
    input  logic              do_pre,
    input  logic              do_rd,
    input  logic              do_wr,
    input  logic [ROW_W-1:0]  row_in,
    output logic              is_open,
    output logic              col_ready,
    output logic              pre_ready,
    output logic              act_ready,
    output logic [ROW_W-1:0]  open_row,
    output logic [ACC_W-1:0]  acc_cnt,
    output logic [BYTE_W-1:0] byte_cnt
);

    localparam logic [TIMER_W-1:0] LD_RCD  = TIMER_W'(T_RCD - 1);
    localparam logic [TIMER_W-1:0] LD_RAS  = TIMER_W'(T_RAS - 1);
    localparam logic [TIMER_W-1:0] LD_RP   = TIMER_W'(T_RP - 1);
    localparam logic [TIMER_W-1:0] LD_CCD  = TIMER_W'(T_CCD - 1);
    localparam logic [TIMER_W-1:0] LD_RTP  = TIMER_W'(T_RTP - 1);
    localparam logic [TIMER_W-1:0] LD_WR   = TIMER_W'(T_WR - 1);
    localparam logic [TIMER_W-1:0] RP_SPAN = TIMER_W'(T_RP);
    localparam logic [ACC_W-1:0]   ACC_CAP = ACC_W'(MAX_ACC);
    localparam logic [BYTE_W-1:0]  B_STEP  = BYTE_W'(BURST_BYTES);

    bk_state_e          st_q, st_d;
    logic [ROW_W-1:0]   row_q, row_d;
    logic [TIMER_W-1:0] col_q, col_d;
    logic [TIMER_W-1:0] pre_q, pre_d;
    logic [TIMER_W-1:0] act_q, act_d;
    logic [TIMER_W-1:0] rec_t;
    logic [ACC_W-1:0]   acc_q, acc_d;
    logic [BYTE_W-1:0]  byt_q, byt_d;

    function automatic logic [TIMER_W-1:0] tick_down(input logic [TIMER_W-1:0] v);
        return (v != '0) ? v - 1'b1 : v;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BK_SHUT;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '1;
            col_q <= '0;
            pre_q <= '0;
            act_q <= '0;
            acc_q <= '0;
            byt_q <= '0;
        end else begin
            row_q <= row_d;
            col_q <= col_d;
            pre_q <= pre_d;
            act_q <= act_d;
            acc_q <= acc_d;
            byt_q <= byt_d;
        end
    end

    // next state and timer loads
    always_comb begin
        st_d  = st_q;
        row_d = row_q;
        col_d = tick_down(col_q);
        pre_d = tick_down(pre_q);
        act_d = tick_down(act_q);
        acc_d = acc_q;
        byt_d = byt_q;
        rec_t = LD_RTP;
        unique case (st_q)
            BK_SHUT: begin
                if (do_act) begin                  // open
                    st_d  = BK_LIVE;
                    row_d = row_in;
                    col_d = LD_RCD;
                    pre_d = LD_RAS;
                    acc_d = '0;
                    byt_d = '0;
                end
            end
            BK_LIVE: begin
                if (do_pre) begin                  // close
                    st_d  = BK_SHUT;
                    row_d = '1;
                    act_d = LD_RP;
                end else if (do_rd || do_wr) begin
                    rec_t = do_wr ? LD_WR : LD_RTP;
                    col_d = LD_CCD;
                    pre_d = (pre_d > rec_t) ? pre_d : rec_t;
                    acc_d = acc_q + 1'b1;
                    byt_d = byt_q + B_STEP;
                    if (acc_d == ACC_CAP) begin    // forced close
                        st_d  = BK_SHUT;
                        row_d = '1;
                        act_d = pre_d + RP_SPAN;
                    end
                end
            end
            default: st_d = BK_SHUT;
        endcase
    end

    // outputs
    always_comb begin
        is_open   = (st_q == BK_LIVE);
        col_ready = (st_q == BK_LIVE) && (col_q == '0);
        pre_ready = (st_q == BK_LIVE) && (pre_q == '0);
        act_ready = (st_q == BK_SHUT) && (act_q == '0);
        open_row  = row_q;
        acc_cnt   = acc_q;
        byte_cnt  = byt_q;
    end

endmodule

// File: rtl/bktrk_act_window.sv
module bktrk_act_window #(
    parameter int LIMIT = 2,
    parameter int T_WIN = 10,
    parameter int WIN_W = 4,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_fire,
    output logic             room,
    output logic [CNT_W-1:0] live_cnt
);

    localparam logic [WIN_W-1:0] LD_WIN = WIN_W'(T_WIN - 1);

    logic [LIMIT-1:0][WIN_W-1:0] slot_q;
    logic [LIMIT-1:0]            busy;
    logic [LIMIT-1:0]            free_sel;
    logic                        taken;

    genvar gi;
    generate
        for (gi = 0; gi < LIMIT; gi++) begin : g_busy
            assign busy[gi] = (slot_q[gi] != '0);
        end
    endgenerate

    always_comb begin
        free_sel = '0;
        taken    = 1'b0;
        for (int i = 0; i < LIMIT; i++) begin
            if (!busy[i] && !taken) begin
                free_sel[i] = 1'b1;
                taken       = 1'b1;
            end
        end
        live_cnt = CNT_W'($countones(busy));
        room     = (live_cnt < CNT_W'(LIMIT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            for (int i = 0; i < LIMIT; i++) begin
                if (act_fire && free_sel[i]) slot_q[i] <= LD_WIN;
                else if (busy[i])            slot_q[i] <= slot_q[i] - 1'b1;
            end
        end
    end

endmodule

// File: rtl/bktrk_cmd_gate.sv
module bktrk_cmd_gate
    import bktrk_pkg::*;
#(
    parameter int NB    = 8,
    parameter int BANKS = 4,
    parameter int RK_W  = 1,
    parameter int BK_W  = 2,
    parameter int GI_W  = 3,
    parameter int ROW_W = 8
) (
    input  logic                      cmd_valid,
    input  logic [1:0]                cmd_op,
    input  logic [RK_W-1:0]           cmd_rank,
    input  logic [BK_W-1:0]           cmd_bank,
    input  logic [ROW_W-1:0]          cmd_row,
    input  logic [NB-1:0]             act_ok,
    input  logic [NB-1:0]             pre_ok,
    input  logic [NB-1:0]             col_ok,
    input  logic [NB-1:0][ROW_W-1:0]  open_row,
    output logic [NB-1:0]             act_go,
    output logic [NB-1:0]             pre_go,
    output logic [NB-1:0]             rd_go,
    output logic [NB-1:0]             wr_go,
    output logic                      bad
);

    logic [GI_W-1:0] g;
    logic            legal;
    logic [NB-1:0]   sel;

    always_comb begin
        g     = GI_W'(cmd_rank) * GI_W'(BANKS) + GI_W'(cmd_bank);
        sel   = '0;
        sel[g] = cmd_valid;
        unique case (bk_op_e'(cmd_op))
            OP_ACT:       legal = act_ok[g];
            OP_PRE:       legal = pre_ok[g];
            OP_RD, OP_WR: legal = col_ok[g] && (open_row[g] == cmd_row);
            default:      legal = 1'b0;
        endcase
        act_go = (legal && bk_op_e'(cmd_op) == OP_ACT) ? sel : '0;
        pre_go = (legal && bk_op_e'(cmd_op) == OP_PRE) ? sel : '0;
        rd_go  = (legal && bk_op_e'(cmd_op) == OP_RD)  ? sel : '0;
        wr_go  = (legal && bk_op_e'(cmd_op) == OP_WR)  ? sel : '0;
        bad    = cmd_valid && !legal;
    end

endmodule

// File: rtl/bank_timing_tracker.sv
module bank_timing_tracker #(
    parameter int RANKS       = 2,
    parameter int BANKS       = 4,
    parameter int ROW_W       = 8,
    parameter int T_RCD       = 3,
    parameter int T_RAS       = 6,
    parameter int T_RP        = 3,
    parameter int T_CCD       = 2,
    parameter int T_RTP       = 2,
    parameter int T_WR        = 4,
    parameter int T_WIN       = 10,
    parameter int ACT_LIMIT   = 2,
    parameter int MAX_ACC     = 4,
    parameter int BURST_BYTES = 32,
    localparam int NB      = RANKS * BANKS,
    localparam int RK_W    = (RANKS > 1) ? $clog2(RANKS) : 1,
    localparam int BK_W    = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int ACC_W   = $clog2(MAX_ACC + 1),
    localparam int BYTE_W  = $clog2(MAX_ACC * BURST_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [RK_W-1:0]   cmd_rank,
    input  logic [BK_W-1:0]   cmd_bank,
    input  logic [ROW_W-1:0]  cmd_row,
    input  logic [RK_W-1:0]   q_rank,
    input  logic [BK_W-1:0]   q_bank,
    input  logic [ROW_W-1:0]  q_row,
    output logic [NB-1:0]     act_ok,
    output logic [NB-1:0]     pre_ok,
    output logic [NB-1:0]     col_ok,
    output logic              q_open,
    output logic              q_hit,
    output logic [ACC_W-1:0]  q_acc,
    output logic [BYTE_W-1:0] q_bytes,
    output logic              timing_err
);

    localparam int GI_W    = (NB > 1) ? $clog2(NB) : 1;
    localparam int TIMER_W = $clog2(T_RAS + T_WR + T_RTP + T_RCD + T_CCD + T_RP + 1);
    localparam int WIN_W   = $clog2(T_WIN + 1);
    localparam int CNT_W   = $clog2(ACT_LIMIT + 1);

    logic [NB-1:0]               bank_open, bank_act;
    logic [NB-1:0][ROW_W-1:0]    open_row;
    logic [NB-1:0][ACC_W-1:0]    acc_v;
    logic [NB-1:0][BYTE_W-1:0]   byt_v;
    logic [NB-1:0]               act_go, pre_go, rd_go, wr_go;
    logic                        bad;
    logic [RANKS-1:0]            room;
    logic [RANKS-1:0]            act_fire;
    logic [RANKS-1:0][CNT_W-1:0] win_live;
    logic [GI_W-1:0]             qg;

    bktrk_cmd_gate #(
        .NB(NB), .BANKS(BANKS), .RK_W(RK_W), .BK_W(BK_W), .GI_W(GI_W), .ROW_W(ROW_W)
    ) gate_i (
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_rank(cmd_rank),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .act_ok(act_ok), .pre_ok(pre_ok), .col_ok(col_ok), .open_row(open_row),
        .act_go(act_go), .pre_go(pre_go), .rd_go(rd_go), .wr_go(wr_go), .bad(bad)
    );

    genvar r, b;
    generate
        for (r = 0; r < RANKS; r++) begin : g_rank
            assign act_fire[r] = |act_go[r*BANKS +: BANKS];
            assign act_ok[r*BANKS +: BANKS] = bank_act[r*BANKS +: BANKS] & {BANKS{room[r]}};

            bktrk_act_window #(
                .LIMIT(ACT_LIMIT), .T_WIN(T_WIN), .WIN_W(WIN_W), .CNT_W(CNT_W)
            ) win_i (
                .clk(clk), .rst_n(rst_n), .act_fire(act_fire[r]),
                .room(room[r]), .live_cnt(win_live[r])
            );

            for (b = 0; b < BANKS; b++) begin : g_bank
                localparam int G = r * BANKS + b;
                bktrk_bank_slot #(
                    .ROW_W(ROW_W), .TIMER_W(TIMER_W), .ACC_W(ACC_W), .BYTE_W(BYTE_W),
                    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_CCD(T_CCD),
                    .T_RTP(T_RTP), .T_WR(T_WR), .MAX_ACC(MAX_ACC),
                    .BURST_BYTES(BURST_BYTES)
                ) slot_i (
                    .clk(clk), .rst_n(rst_n),
                    .do_act(act_go[G]), .do_pre(pre_go[G]),
                    .do_rd(rd_go[G]), .do_wr(wr_go[G]), .row_in(cmd_row),
                    .is_open(bank_open[G]), .col_ready(col_ok[G]),
                    .pre_ready(pre_ok[G]), .act_ready(bank_act[G]),
                    .open_row(open_row[G]), .acc_cnt(acc_v[G]), .byte_cnt(byt_v[G])
                );
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   timing_err <= 1'b0;
        else if (bad) timing_err <= 1'b1;
    end

    always_comb begin
        qg      = GI_W'(q_rank) * GI_W'(BANKS) + GI_W'(q_bank);
        q_open  = bank_open[qg];
        q_hit   = bank_open[qg] && (open_row[qg] == q_row);
        q_acc   = acc_v[qg];
        q_bytes = byt_v[qg];
    end

endmodule

// File: rtl/bktrk_chk.sv
module bktrk_chk #(
    parameter int NB        = 8,
    parameter int RANKS     = 2,
    parameter int BANKS     = 4,
    parameter int ACT_LIMIT = 2,
    parameter int CNT_W     = 2,
    parameter int T_RCD     = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NB-1:0]             act_go,
    input logic [NB-1:0]             pre_go,
    input logic [NB-1:0]             col_ok,
    input logic [NB-1:0]             bank_open,
    input logic [RANKS-1:0][CNT_W-1:0] win_live,
    input logic                      timing_err
);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timing_err |=> timing_err);

    // R2
    act_on_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|act_go) |-> ((act_go & bank_open) == '0));

    // R3
    pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pre_go) |=> ((bank_open & $past(pre_go)) == '0));

    generate
        if (T_RCD > 1) begin : g_rcd
            // R2
            act_col_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (|act_go) |=> ((col_ok & $past(act_go)) == '0));
        end
        for (genvar r = 0; r < RANKS; r++) begin : g_win
            // R7
            win_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (|act_go[r*BANKS +: BANKS]) |-> (win_live[r] < CNT_W'(ACT_LIMIT)));
            // R7
            win_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                win_live[r] <= CNT_W'(ACT_LIMIT));
        end
    endgenerate

endmodule

bind bank_timing_tracker bktrk_chk #(
    .NB(NB), .RANKS(RANKS), .BANKS(BANKS), .ACT_LIMIT(ACT_LIMIT),
    .CNT_W(CNT_W), .T_RCD(T_RCD)
) chk_i (
    .clk(clk), .rst_n(rst_n), .act_go(act_go), .pre_go(pre_go),
    .col_ok(col_ok), .bank_open(bank_open), .win_live(win_live),
    .timing_err(timing_err)
);

// File: tb/bank_timing_tracker_tb_top.sv
`timescale 1ns/1ps
module bank_timing_tracker_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic       cmd_rank = 1'b0;
    logic [1:0] cmd_bank = 2'd0;
    logic [7:0] cmd_row = 8'd0;
    logic       q_rank = 1'b0;
    logic [1:0] q_bank = 2'd0;
    logic [7:0] q_row = 8'd0;
    logic [7:0] act_ok, pre_ok, col_ok;
    logic       q_open, q_hit;
    logic [2:0] q_acc;
    logic [7:0] q_bytes;
    logic       timing_err;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bank_timing_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .q_rank(q_rank), .q_bank(q_bank), .q_row(q_row),
        .act_ok(act_ok), .pre_ok(pre_ok), .col_ok(col_ok),
        .q_open(q_open), .q_hit(q_hit), .q_acc(q_acc), .q_bytes(q_bytes),
        .timing_err(timing_err)
    );

    typedef struct packed {
        logic [1:0] op;
        logic       rk;
        logic [1:0] bk;
        logic [7:0] row;
        logic [7:0] wt;
    } step_t;

    // op: 0 ACT, 1 PRE, 2 RD, 3 WR; wt = expected cycles spent waiting for the flag
    localparam step_t STEPS [14] = '{
        '{2'd0, 1'b0, 2'd0, 8'd5, 8'd0},
        '{2'd2, 1'b0, 2'd0, 8'd5, 8'd2},
        '{2'd2, 1'b0, 2'd0, 8'd5, 8'd1},
        '{2'd3, 1'b0, 2'd0, 8'd5, 8'd1},
        '{2'd1, 1'b0, 2'd0, 8'd0, 8'd3},
        '{2'd0, 1'b0, 2'd0, 8'd7, 8'd2},
        '{2'd0, 1'b0, 2'd1, 8'd3, 8'd0},
        '{2'd0, 1'b0, 2'd2, 8'd4, 8'd8},
        '{2'd0, 1'b1, 2'd0, 8'd1, 8'd0},
        '{2'd2, 1'b0, 2'd1, 8'd3, 8'd0},
        '{2'd2, 1'b0, 2'd1, 8'd3, 8'd1},
        '{2'd2, 1'b0, 2'd1, 8'd3, 8'd1},
        '{2'd2, 1'b0, 2'd1, 8'd3, 8'd1},
        '{2'd0, 1'b0, 2'd1, 8'd9, 8'd4}
    };

    function automatic string req_tag(input int i);
        case (i)
            1:       return "R2";
            2, 3, 4: return "R4";
            5:       return "R3";
            7:       return "R7";
            13:      return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic rk, input logic [1:0] bk,
                         input logic [7:0] row);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_rank  = rk;
        cmd_bank  = bk;
        cmd_row   = row;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic logic flag_for(input logic [1:0] op, input int g);
        case (op)
            2'd0:    return act_ok[g];
            2'd1:    return pre_ok[g];
            default: return col_ok[g];
        endcase
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        check("R1 act_ok", int'(act_ok), 8'hFF);
        check("R1 col_ok", int'(col_ok), 0);
        check("R1 pre_ok", int'(pre_ok), 0);
        check("R1 q_open", int'(q_open), 0);
        check("R1 timing_err", int'(timing_err), 0);

        for (int i = 0; i < 14; i++) begin
            int w;
            int g;
            w = 0;
            g = int'(STEPS[i].rk) * 4 + int'(STEPS[i].bk);
            while (!flag_for(STEPS[i].op, g) && w < 60) begin
                @(negedge clk);
                w++;
            end
            check(req_tag(i), w, int'(STEPS[i].wt));
            issue(STEPS[i].op, STEPS[i].rk, STEPS[i].bk, STEPS[i].row);
            if (i == 8) begin
                // R8: rank 1 bank 0 is global bit 4
                check("R8 act_ok bit4", int'(act_ok[4]), 0);
                check("R8 act_ok bit3", int'(act_ok[3]), 1);
            end
            if (i == 12) begin
                q_rank = 1'b0; q_bank = 2'd1; q_row = 8'd3;
                #0.1;
                check("R6 closed", int'(q_open), 0);
                check("R5 acc", int'(q_acc), 4);
                check("R5 bytes", int'(q_bytes), 128);
            end
        end

        q_rank = 1'b0; q_bank = 2'd1; q_row = 8'd9;
        #0.1;
        check("R9 hit", int'(q_hit), 1);
        check("R5 acc cleared", int'(q_acc), 0);
        check("R5 bytes cleared", int'(q_bytes), 0);
        q_row = 8'd8;
        #0.1;
        check("R9 miss", int'(q_hit), 0);
        check("R10 no err", int'(timing_err), 0);

        // R10: read to a closed bank
        issue(2'd2, 1'b0, 2'd3, 8'd0);
        check("R10 err set", int'(timing_err), 1);
        check("R10 bank3 untouched", int'(act_ok[3]), 1);
        q_bank = 2'd3;
        #0.1;
        check("R10 bank3 closed", int'(q_open), 0);
        repeat (2) @(negedge clk);
        check("R10 err held", int'(timing_err), 1);

        do_reset();
        q_bank = 2'd1;
        #0.1;
        check("R1 err cleared", int'(timing_err), 0);
        check("R1 bank closed", int'(q_open), 0);

        // R10: read on a row other than the open one
        issue(2'd0, 1'b0, 2'd1, 8'd9);
        repeat (3) @(negedge clk);
        issue(2'd2, 1'b0, 2'd1, 8'd8);
        check("R10 row miss err", int'(timing_err), 1);
        check("R10 acc unchanged", int'(q_acc), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule